// File: doc/BRIEF.md
# Three-Voice Tune Fetcher With Immediate-Operand Substitution

This block plays back tune data stored as groups of three note bytes, one byte per voice, and turns the current notes into a single 4-bit mixed square-wave level. Each voice owns a phase accumulator that adds its note value on every sample tick. The accumulator's top bit is that voice's square wave. The number of voices that are high sets the output level.

The level reaches the CPU through the instruction stream. When the CPU fetches the load-immediate opcode and the next sequential fetch returns the operand byte `$F2`, the block drives the level onto the data bus in place of that operand. All other fetch bytes pass through unchanged. Separate strobes step the tune forward one position, rewind it, or select one of several stored tunes. A fill port writes the tune storage. A 16-bit output reports the byte offset within the current tune.

Top module: `chiptune_fetcher`

## Requirements
- R1: After reset, or while rst_ni is low, pos_o is 0. All voice phases and notes are 0, so a substituted operand reads as 0.
- R2: A pulse on advance_i moves pos_o up by 3, from one group of three note bytes to the next. Without a strobe, pos_o keeps its value.
- R3: A pulse on rewind_i returns pos_o to 0 and keeps the selected tune.
- R4: A pulse on load_i with load_idx_i below NUM_TUNES selects that tune, returns pos_o to 0 and clears all voice phases. An index of NUM_TUNES or above is ignored: pos_o and the phases stay as they were.
- R5: The cycle after a new position is reached, its three bytes are read (voice k at offset pos_o+k). If any of them equals 1, that is the end of the tune: pos_o returns to 0 and the voices reload from the start of the tune.
- R6: A note byte of 0 leaves that voice's previous note in place. Any other byte (besides 1) becomes the voice's new note.
- R7: On each tick_i, every voice phase (8 bits, wrapping) adds its note. The level is 5 times the number of phases whose bit 7 is set, giving 0, 5, 10 or 15 in bits 3:0 with bits 7:4 zero.
- R8: data_o equals fetch_data_i, except in one case. If a fetch with data $F2 immediately follows a fetch with data $A9, and its address is the previous address plus 1 (16-bit wrap), then data_o carries the level instead. Fetches with fetch_i low are not counted.
- R9: A pulse on mem_we_i writes mem_wdata_i to the byte at tune mem_waddr_i[10:8], offset mem_waddr_i[7:0].
- R10: Advancing from the last whole group that fits inside the tune (offset 252 for 256-byte tunes) wraps pos_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_we_i | input | 1 | Tune storage write strobe |
| mem_waddr_i | input | 11 | Tune storage write address {tune, offset} |
| mem_wdata_i | input | 8 | Tune storage write data |
| load_i | input | 1 | Tune select strobe |
| load_idx_i | input | 3 | Tune index for load_i |
| rewind_i | input | 1 | Return to the start of the tune |
| advance_i | input | 1 | Step to the next position |
| tick_i | input | 1 | Sample tick for the voice phases |
| fetch_i | input | 1 | CPU fetch cycle valid |
| fetch_addr_i | input | 16 | CPU fetch address |
| fetch_data_i | input | 8 | Byte read from program memory |
| data_o | output | 8 | Byte returned to the CPU |
| pos_o | output | 16 | Byte offset within the current tune |

## Verification
Several rules are checked on every cycle. The position always sits on a group boundary inside the tune. Each strobe moves the position only in its permitted way, and the position holds when no strobe arrives. Substitution replaces only an `$F2` byte and only with one of the four legal levels, and idle cycles pass the bus through. Other behaviour depends on stored note data and on accumulated ticks, so only the bench scenarios can show it. This covers holding a note on a 0 byte, wrapping at an end marker, reloading the voices after a rewind or a wrap, an ignored out-of-range tune index, and the exact level after a given number of ticks.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int VOICES = 3;
  localparam int LEVEL_MAX = 15;
  localparam int LEVEL_STEP = LEVEL_MAX / VOICES;

  typedef logic [7:0] byte_t;
  typedef logic [VOICES-1:0][7:0] note_vec_t;

  localparam byte_t OPC_LDI   = 8'hA9;
  localparam byte_t OPD_MAGIC = 8'hF2;
  localparam byte_t END_NOTE  = 8'h01;
  localparam byte_t HOLD_NOTE = 8'h00;
endpackage

// File: rtl/cf_store.sv
module cf_store
  import cf_pkg::*;
#(
  parameter int NUM_TUNES  = 7,
  parameter int TUNE_BYTES = 256,
  localparam int TUNE_W = $clog2(NUM_TUNES),
  localparam int POS_W  = $clog2(TUNE_BYTES),
  localparam int AW     = TUNE_W + POS_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  byte_t             wdata_i,
  input  logic [TUNE_W-1:0] rtune_i,
  input  logic [POS_W-1:0]  rpos_i,
  output note_vec_t         rdata_o
);
  localparam int DEPTH = 1 << AW;

  byte_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar k = 0; k < VOICES; k++) begin : g_rd
    logic [POS_W-1:0] off;
    assign off = rpos_i + POS_W'(k);
    assign rdata_o[k] = mem[{rtune_i, off}];
  end
endmodule

// File: rtl/cf_sequencer.sv
module cf_sequencer
  import cf_pkg::*;
#(
  parameter int NUM_TUNES  = 7,
  parameter int TUNE_BYTES = 256,
  localparam int TUNE_W = $clog2(NUM_TUNES),
  localparam int POS_W  = $clog2(TUNE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TUNE_W-1:0] load_idx_i,
  input  logic              rewind_i,
  input  logic              advance_i,
  input  note_vec_t         notes_i,
  output logic [TUNE_W-1:0] tune_o,
  output logic [POS_W-1:0]  pos_o,
  output note_vec_t         freq_o,
  output logic              restart_o
);
  // last group start that keeps all three bytes inside the tune
  localparam int LAST_POS = ((TUNE_BYTES - VOICES) / VOICES) * VOICES;

  logic [TUNE_W-1:0] tune_q;
  logic [POS_W-1:0]  pos_q;
  logic              refresh_q;
  note_vec_t         freq_q;
  logic              load_ok, end_hit;
  logic [POS_W:0]    nxt;
  logic [POS_W-1:0]  nxt_pos;

  assign load_ok = load_i && ({1'b0, load_idx_i} < (TUNE_W+1)'(NUM_TUNES));

  always_comb begin
    end_hit = 1'b0;
    for (int k = 0; k < VOICES; k++) begin
      if (notes_i[k] == END_NOTE) end_hit = 1'b1;
    end
  end

  assign nxt     = {1'b0, pos_q} + (POS_W+1)'(VOICES);
  assign nxt_pos = (int'(nxt) > LAST_POS) ? '0 : nxt[POS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_q    <= '0;
      pos_q     <= '0;
      refresh_q <= 1'b1;
      freq_q    <= '0;
    end else begin
      refresh_q <= 1'b0;
      if (load_ok) begin
        tune_q    <= load_idx_i;
        pos_q     <= '0;
        refresh_q <= 1'b1;
      end else if (rewind_i || (refresh_q && end_hit)) begin
        pos_q     <= '0;
        refresh_q <= 1'b1;
      end else if (advance_i) begin
        pos_q     <= nxt_pos;
        refresh_q <= 1'b1;
      end
      if (refresh_q && !end_hit) begin
        for (int k = 0; k < VOICES; k++) begin
          if (notes_i[k] != HOLD_NOTE) freq_q[k] <= notes_i[k];
        end
      end
    end
  end

  assign tune_o    = tune_q;
  assign pos_o     = pos_q;
  assign freq_o    = freq_q;
  assign restart_o = load_ok;
endmodule

// File: rtl/cf_voice.sv
module cf_voice
  import cf_pkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  tick_i,
  input  byte_t step_i,
  output logic  sq_o
);
  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + PHASE_W'(step_i);
  end

  assign sq_o = acc_q[PHASE_W-1];
endmodule

// File: rtl/cf_patch.sv
module cf_patch
  import cf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  byte_t             fetch_data_i,
  input  byte_t             level_i,
  output byte_t             data_o
);
  logic              armed_q;
  logic [ADDR_W-1:0] next_addr_q;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      next_addr_q <= '0;
    end else if (fetch_i) begin
      armed_q     <= (fetch_data_i == OPC_LDI);
      next_addr_q <= fetch_addr_i + ADDR_W'(1);
    end
  end

  assign hit = fetch_i && armed_q && (fetch_addr_i == next_addr_q)
               && (fetch_data_i == OPD_MAGIC);
  assign data_o = hit ? level_i : fetch_data_i;
endmodule

// File: rtl/chiptune_fetcher.sv
module chiptune_fetcher
  import cf_pkg::*;
#(
  parameter int NUM_TUNES  = 7,
  parameter int TUNE_BYTES = 256,
  parameter int PHASE_W    = 8,
  parameter int ADDR_W     = 16,
  localparam int TUNE_W = $clog2(NUM_TUNES),
  localparam int POS_W  = $clog2(TUNE_BYTES),
  localparam int AW     = TUNE_W + POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_we_i,
  input  logic [AW-1:0]     mem_waddr_i,
  input  logic [7:0]        mem_wdata_i,
  input  logic              load_i,
  input  logic [TUNE_W-1:0] load_idx_i,
  input  logic              rewind_i,
  input  logic              advance_i,
  input  logic              tick_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [7:0]        fetch_data_i,
  output logic [7:0]        data_o,
  output logic [15:0]       pos_o
);
  note_vec_t         notes, freq;
  logic [TUNE_W-1:0] tune;
  logic [POS_W-1:0]  pos;
  logic              restart;
  logic [VOICES-1:0] sq;
  byte_t             level;

  cf_store #(.NUM_TUNES(NUM_TUNES), .TUNE_BYTES(TUNE_BYTES)) u_store (
    .clk_i   (clk_i),
    .we_i    (mem_we_i),
    .waddr_i (mem_waddr_i),
    .wdata_i (mem_wdata_i),
    .rtune_i (tune),
    .rpos_i  (pos),
    .rdata_o (notes)
  );

  cf_sequencer #(.NUM_TUNES(NUM_TUNES), .TUNE_BYTES(TUNE_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_idx_i (load_idx_i),
    .rewind_i   (rewind_i),
    .advance_i  (advance_i),
    .notes_i    (notes),
    .tune_o     (tune),
    .pos_o      (pos),
    .freq_o     (freq),
    .restart_o  (restart)
  );

  for (genvar k = 0; k < VOICES; k++) begin : g_voice
    cf_voice #(.PHASE_W(PHASE_W)) u_voice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (restart),
      .tick_i (tick_i),
      .step_i (freq[k]),
      .sq_o   (sq[k])
    );
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < VOICES; k++) begin
      if (sq[k]) level = level + byte_t'(LEVEL_STEP);
    end
  end

  cf_patch #(.ADDR_W(ADDR_W)) u_patch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_i      (fetch_i),
    .fetch_addr_i (fetch_addr_i),
    .fetch_data_i (fetch_data_i),
    .level_i      (level),
    .data_o       (data_o)
  );

  assign pos_o = 16'(pos);
endmodule

// File: rtl/chiptune_fetcher_chk.sv
module chiptune_fetcher_chk #(
  parameter int NUM_TUNES  = 7,
  parameter int TUNE_BYTES = 256,
  parameter int TUNE_W     = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [TUNE_W-1:0] load_idx_i,
  input logic              rewind_i,
  input logic              advance_i,
  input logic              fetch_i,
  input logic [7:0]        fetch_data_i,
  input logic [7:0]        data_o,
  input logic [15:0]       pos_o
);
  localparam int LAST_POS = ((TUNE_BYTES - 3) / 3) * 3;
  logic load_ok;
  assign load_ok = load_i && (int'(load_idx_i) < NUM_TUNES);

  assert_pos_grid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o % 16'd3 == 16'd0) && (int'(pos_o) <= LAST_POS));

  assert_pos_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !rewind_i && !load_ok) |=> (pos_o == $past(pos_o)) || (pos_o == 16'd0));

  assert_pos_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !rewind_i && !load_ok) |=> (pos_o == 16'd0) || (pos_o == $past(pos_o) + 16'd3));

  assert_rewind_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> pos_o == 16'd0);

  assert_load_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ok |=> pos_o == 16'd0);

  assert_level_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && data_o != fetch_data_i) |->
      (data_o == 8'd0 || data_o == 8'd5 || data_o == 8'd10 || data_o == 8'd15));

  assert_only_magic_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i && data_o != fetch_data_i) |-> fetch_data_i == 8'hF2);

  assert_idle_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_i |-> data_o == fetch_data_i);
endmodule

bind chiptune_fetcher chiptune_fetcher_chk #(
  .NUM_TUNES(NUM_TUNES), .TUNE_BYTES(TUNE_BYTES), .TUNE_W(TUNE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .load_idx_i   (load_idx_i),
  .rewind_i     (rewind_i),
  .advance_i    (advance_i),
  .fetch_i      (fetch_i),
  .fetch_data_i (fetch_data_i),
  .data_o       (data_o),
  .pos_o        (pos_o)
);

// File: tb/chiptune_fetcher_test.sv
`timescale 1ns/1ps
module chiptune_fetcher_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_we_i = 1'b0;
  logic [10:0] mem_waddr_i = '0;
  logic [7:0]  mem_wdata_i = '0;
  logic        load_i = 1'b0;
  logic [2:0]  load_idx_i = '0;
  logic        rewind_i = 1'b0;
  logic        advance_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        fetch_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic [7:0]  fetch_data_i = '0;
  logic [7:0]  data_o;
  logic [15:0] pos_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_acc [3];
  logic [7:0] m_freq [3];

  always #2 clk_i = ~clk_i;

  chiptune_fetcher uut (.*);

  // {addr[31:16], data[15:8], expected data_o[7:0]} with level 0
  localparam logic [31:0] VEC [14] = '{
    {16'h1000, 8'hA9, 8'hA9}, {16'h1001, 8'hF2, 8'h00},
    {16'h1002, 8'hF2, 8'hF2}, {16'h2000, 8'hA9, 8'hA9},
    {16'h2002, 8'hF2, 8'hF2}, {16'h3000, 8'hA8, 8'hA8},
    {16'h3001, 8'hF2, 8'hF2}, {16'h4000, 8'hA9, 8'hA9},
    {16'h4001, 8'hF3, 8'hF3}, {16'h5000, 8'hA9, 8'hA9},
    {16'h5001, 8'hA9, 8'hA9}, {16'h5002, 8'hF2, 8'h00},
    {16'hFFFF, 8'hA9, 8'hA9}, {16'h0000, 8'hF2, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk_i);
    fetch_i = 1'b1; fetch_addr_i = a; fetch_data_i = d;
    #1 q = data_o;
    @(negedge clk_i);
    fetch_i = 1'b0;
  endtask

  task automatic wr(input int tune, input int off, input int val);
    @(negedge clk_i);
    mem_we_i = 1'b1; mem_waddr_i = {3'(tune), 8'(off)}; mem_wdata_i = 8'(val);
    @(negedge clk_i);
    mem_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_load(input int idx);
    @(negedge clk_i); load_i = 1'b1; load_idx_i = 3'(idx);
    @(negedge clk_i); load_i = 1'b0;
    if (idx < 7) for (int k = 0; k < 3; k++) m_acc[k] = '0;
  endtask

  task automatic do_advance();
    @(negedge clk_i); advance_i = 1'b1;
    @(negedge clk_i); advance_i = 1'b0;
  endtask

  task automatic do_rewind();
    @(negedge clk_i); rewind_i = 1'b1;
    @(negedge clk_i); rewind_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      for (int k = 0; k < 3; k++) m_acc[k] = m_acc[k] + m_freq[k];
    end
  endtask

  task automatic set_freq(input int a, input int b, input int c);
    m_freq[0] = 8'(a); m_freq[1] = 8'(b); m_freq[2] = 8'(c);
  endtask

  task automatic check_level(input string req);
    logic [7:0] q;
    int lvl;
    lvl = 0;
    for (int k = 0; k < 3; k++) if (m_acc[k][7]) lvl += 5;
    fetch(16'hE000, 8'hA9, q);
    fetch(16'hE001, 8'hF2, q);
    chk(req, int'(q), lvl);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired (all) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] q;
    for (int k = 0; k < 3; k++) begin m_acc[k] = '0; m_freq[k] = '0; end
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 reset position", int'(pos_o), 0);

    // R8 substitution patterns, level 0 while no ticks
    for (int i = 0; i < 14; i++) begin
      fetch(VEC[i][31:16], VEC[i][15:8], q);
      chk($sformatf("R8 vector %0d", i), int'(q), int'(VEC[i][7:0]));
    end

    // R9 fill: tune 1 = (10,20,30) (0,40,0) (1,0,0); tune 2 all 2
    wr(1, 0, 10); wr(1, 1, 20); wr(1, 2, 30);
    wr(1, 3, 0);  wr(1, 4, 40); wr(1, 5, 0);
    wr(1, 6, 1);  wr(1, 7, 0);  wr(1, 8, 0);
    for (int i = 0; i < 256; i++) wr(2, i, 2);

    do_load(1);
    chk("R4 load position", int'(pos_o), 0);
    idle(1);
    set_freq(10, 20, 30);
    ticks(8);
    check_level("R7 R9 level after 8 ticks");

    do_advance();
    chk("R2 advance by 3", int'(pos_o), 3);
    idle(1);
    set_freq(10, 40, 30);
    ticks(5);
    check_level("R6 zero note holds");
    idle(3);
    chk("R2 hold without strobe", int'(pos_o), 3);

    do_advance();
    chk("R5 reach end group", int'(pos_o), 6);
    idle(1);
    chk("R5 end marker wraps", int'(pos_o), 0);
    idle(1);
    set_freq(10, 20, 30);
    ticks(2);
    check_level("R5 voices reloaded");

    do_advance();
    idle(2);
    do_rewind();
    chk("R3 rewind position", int'(pos_o), 0);
    idle(1);
    ticks(3);
    check_level("R3 rewind reloads start");
    do_advance();
    idle(1);
    set_freq(10, 40, 30);
    ticks(3);
    check_level("R3 tune kept after rewind");

    do_load(2);
    idle(1);
    set_freq(2, 2, 2);
    for (int i = 0; i < 84; i++) do_advance();
    chk("R10 last group", int'(pos_o), 252);
    do_advance();
    chk("R10 wrap past tune end", int'(pos_o), 0);

    do_advance(); do_advance();
    ticks(60);
    do_load(7);
    chk("R4 bad index keeps position", int'(pos_o), 6);
    ticks(4);
    check_level("R4 bad index keeps phases");

    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk("R1 async reset position", int'(pos_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int k = 0; k < 3; k++) begin m_acc[k] = '0; m_freq[k] = '0; end
    idle(2);
    ticks(3);
    check_level("R1 level zero after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule